// File: doc/BRIEF.md
# Input Current Error Calculator

This block produces the three error signals that steer the input side of a three-phase converter toward unity power factor. For each line pair it forms the line-to-line current from two phase currents. It builds a current reference by scaling the matching input line voltage with a regulator gain word. It takes a rate-of-change term from the voltage across the input inductor, which is the line voltage minus the capacitor line voltage. It then subtracts the proportional and derivative feedback from the scaled reference.

A sample is offered with `in_valid`. The three errors come out together, with `out_valid`, a fixed three cycles later. Three gain constants are held in registers: one for the reference, one for the proportional term and one for the derivative term. They are loaded through a small write port, and a write is only accepted while no sample is in flight. Picking a switch pair from the errors is left to the next block.

Top module: `ierr_calc`

## Requirements
- R1: After a synchronous reset, the three errors read 0 and `out_valid` is 0. The reference gain reads 1.0 (256), the proportional gain 1.0 (256) and the derivative gain 0.
- R2: Line currents pair the phases as follows: `err_ab` uses a−b, `err_bc` uses b−c and `err_ca` uses c−a. Each channel uses the matching line voltage and capacitor voltage (ab, bc, ca).
- R3: The reference term is the line voltage times the signed `gain_word`, arithmetically shifted right by FRAC (8). That result is then multiplied by the reference gain.
- R4: The derivative term is the derivative gain times (line voltage − capacitor line voltage).
- R5: Each error is (reference term − proportional gain × line current − derivative term), arithmetically shifted right by FRAC (8). The shift rounds toward minus infinity, and every product is kept at full width before the shift.
- R6: A shifted result above 32767 is output as 32767, and one below −32768 is output as −32768.
- R7: `out_valid` is high for exactly one cycle, three cycles after each cycle in which `in_valid` is high. Samples offered on consecutive cycles come out on consecutive cycles, in order.
- R8: While `out_valid` is low, the three error outputs keep their last values.
- R9: A gain write with `wr_en` high while idle loads `wr_data` into the gain selected by `wr_sel`: 0 selects the reference gain, 1 the proportional gain and 2 the derivative gain. The new value applies to samples offered after the write cycle.
- R10: A write is ignored when `in_valid` is high in the same cycle, or when a sample still occupies the first or second pipeline stage. A write with `wr_sel` = 3 is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present on the data inputs |
| ph_a | input | DW | Phase current a, signed |
| ph_b | input | DW | Phase current b, signed |
| ph_c | input | DW | Phase current c, signed |
| vl_ab | input | DW | Input line voltage ab, signed |
| vl_bc | input | DW | Input line voltage bc, signed |
| vl_ca | input | DW | Input line voltage ca, signed |
| vc_ab | input | DW | Input capacitor line voltage ab, signed |
| vc_bc | input | DW | Input capacitor line voltage bc, signed |
| vc_ca | input | DW | Input capacitor line voltage ca, signed |
| gain_word | input | GW | Regulator gain word, signed, FRAC fraction bits |
| wr_en | input | 1 | Gain write strobe |
| wr_sel | input | 2 | Gain select (0 reference, 1 proportional, 2 derivative) |
| wr_data | input | GW | Gain value, signed, FRAC fraction bits |
| err_ab | output | OW | Error for pair ab, signed |
| err_bc | output | OW | Error for pair bc, signed |
| err_ca | output | OW | Error for pair ca, signed |
| out_valid | output | 1 | Errors valid |

## Verification
The bench builds the block with DW, GW and OW all set to 16, FRAC set to 8, and reset gains of 1.0, 1.0 and 0. At these widths, full-scale line voltages with a near-full gain word push the shifted sum past both the upper and the lower rail. At the same time, a single unit of line current with a half proportional gain lands on −0.5, which exposes the floor rounding of the shift. Gain writes are attempted in each busy cycle of a sample's passage, so that both the in-flight sample and the next one show that the old gains were kept.

// File: rtl/ierr_pkg.sv
package ierr_pkg;

    // number of line pairs handled in parallel
    localparam int NCH = 3;

    // gain register select codes on the write port
    typedef enum logic [1:0] {
        GS_REF  = 2'd0,
        GS_PROP = 2'd1,
        GS_DERV = 2'd2,
        GS_NONE = 2'd3
    } gsel_e;

endpackage

// File: rtl/ierr_gain_regs.sv
module ierr_gain_regs
    import ierr_pkg::*;
#(
    parameter int GW     = 16,
    parameter int KR_RST = 256,
    parameter int KP_RST = 256,
    parameter int KD_RST = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 busy,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic signed [GW-1:0] wr_data,
    output logic signed [GW-1:0] kr,
    output logic signed [GW-1:0] kp,
    output logic signed [GW-1:0] kd
);

    logic take;
    assign take = wr_en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            kr <= GW'(KR_RST);
            kp <= GW'(KP_RST);
            kd <= GW'(KD_RST);
        end else if (take) begin
            case (gsel_e'(wr_sel))
                GS_REF:  kr <= wr_data;
                GS_PROP: kp <= wr_data;
                GS_DERV: kd <= wr_data;
                default: ;
            endcase
        end
    end

    // gains never move while a sample is in flight
    p_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable({kr, kp, kd}));

    // an idle write to the reference gain lands next cycle
    p_wr_ref_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && wr_sel == 2'd0) |=> kr == $past(wr_data));

endmodule

// File: rtl/ierr_lane.sv
module ierr_lane #(
    parameter int DW   = 16,
    parameter int GW   = 16,
    parameter int OW   = 16,
    parameter int FRAC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en0,
    input  logic                 en1,
    input  logic                 en2,
    input  logic signed [DW-1:0] i_x,
    input  logic signed [DW-1:0] i_y,
    input  logic signed [DW-1:0] v_line,
    input  logic signed [DW-1:0] v_cap,
    input  logic signed [GW-1:0] g,
    input  logic signed [GW-1:0] kr,
    input  logic signed [GW-1:0] kp,
    input  logic signed [GW-1:0] kd,
    output logic signed [OW-1:0] err
);

    localparam int LW = DW + 1;          // line current / inductor voltage
    localparam int PW = DW + GW;         // voltage x gain word
    localparam int TW = DW + 2*GW + 2;   // summing width
    localparam logic signed [TW-1:0] SMAX = TW'((2**(OW-1)) - 1);
    localparam logic signed [TW-1:0] SMIN = -SMAX - TW'(1);

    // stage 1: differences
    logic signed [LW-1:0] il1, dv1;
    logic signed [DW-1:0] v1;
    logic signed [GW-1:0] g1;

    always_ff @(posedge clk) begin
        if (rst) begin
            il1 <= '0;
            dv1 <= '0;
            v1  <= '0;
            g1  <= '0;
        end else if (en0) begin
            il1 <= LW'(i_x) - LW'(i_y);
            dv1 <= LW'(v_line) - LW'(v_cap);
            v1  <= v_line;
            g1  <= g;
        end
    end

    // stage 2: full-width products
    logic signed [PW-1:0] refp2;
    logic signed [TW-1:0] p2, d2;

    always_ff @(posedge clk) begin
        if (rst) begin
            refp2 <= '0;
            p2    <= '0;
            d2    <= '0;
        end else if (en1) begin
            refp2 <= (PW'(v1) * PW'(g1)) >>> FRAC;
            p2    <= TW'(il1) * TW'(kp);
            d2    <= TW'(dv1) * TW'(kd);
        end
    end

    // stage 3: reference gain, sum, scale, clamp
    logic signed [TW-1:0] rterm, sum3, shf3;
    logic signed [OW-1:0] sat3;

    assign rterm = TW'(refp2) * TW'(kr);
    assign sum3  = rterm - p2 - d2;
    assign shf3  = sum3 >>> FRAC;

    always_comb begin
        if (shf3 > SMAX)      sat3 = OW'(SMAX);
        else if (shf3 < SMIN) sat3 = OW'(SMIN);
        else                  sat3 = shf3[OW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)      err <= '0;
        else if (en2) err <= sat3;
    end

    // output register holds whenever no result is retired
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !en2 |=> $stable(err));

endmodule

// File: rtl/ierr_calc.sv
module ierr_calc
    import ierr_pkg::*;
#(
    parameter int DW     = 16,
    parameter int GW     = 16,
    parameter int OW     = 16,
    parameter int FRAC   = 8,
    parameter int KR_RST = 256,
    parameter int KP_RST = 256,
    parameter int KD_RST = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] ph_a,
    input  logic signed [DW-1:0] ph_b,
    input  logic signed [DW-1:0] ph_c,
    input  logic signed [DW-1:0] vl_ab,
    input  logic signed [DW-1:0] vl_bc,
    input  logic signed [DW-1:0] vl_ca,
    input  logic signed [DW-1:0] vc_ab,
    input  logic signed [DW-1:0] vc_bc,
    input  logic signed [DW-1:0] vc_ca,
    input  logic signed [GW-1:0] gain_word,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic signed [GW-1:0] wr_data,
    output logic signed [OW-1:0] err_ab,
    output logic signed [OW-1:0] err_bc,
    output logic signed [OW-1:0] err_ca,
    output logic                 out_valid
);

    // channel-indexed views of the inputs: index 0 = a / ab, 1 = b / bc, 2 = c / ca
    logic signed [DW-1:0] ph [NCH];
    logic signed [DW-1:0] vl [NCH];
    logic signed [DW-1:0] vc [NCH];
    logic signed [OW-1:0] er [NCH];

    assign ph[0] = ph_a;  assign ph[1] = ph_b;  assign ph[2] = ph_c;
    assign vl[0] = vl_ab; assign vl[1] = vl_bc; assign vl[2] = vl_ca;
    assign vc[0] = vc_ab; assign vc[1] = vc_bc; assign vc[2] = vc_ca;

    assign err_ab = er[0];
    assign err_bc = er[1];
    assign err_ca = er[2];

    // valid pipeline
    logic vld1, vld2, busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld1      <= 1'b0;
            vld2      <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            vld1      <= in_valid;
            vld2      <= vld1;
            out_valid <= vld2;
        end
    end

    assign busy = in_valid | vld1 | vld2;

    logic signed [GW-1:0] kr, kp, kd;

    ierr_gain_regs #(
        .GW(GW), .KR_RST(KR_RST), .KP_RST(KP_RST), .KD_RST(KD_RST)
    ) u_gains (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .kr      (kr),
        .kp      (kp),
        .kd      (kd)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_lane
        ierr_lane #(
            .DW(DW), .GW(GW), .OW(OW), .FRAC(FRAC)
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .en0    (in_valid),
            .en1    (vld1),
            .en2    (vld2),
            .i_x    (ph[k]),
            .i_y    (ph[(k + 1) % NCH]),
            .v_line (vl[k]),
            .v_cap  (vc[k]),
            .g      (gain_word),
            .kr     (kr),
            .kp     (kp),
            .kd     (kd),
            .err    (er[k])
        );
    end

    // every accepted sample retires exactly three cycles later
    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid);

endmodule

// File: tb/tb_ierr_calc.sv
`timescale 1ns/1ps
module tb_ierr_calc;

    localparam int DW = 16, GW = 16, OW = 16, FRAC = 8;

    typedef struct packed {
        int ia; int ib; int ic;
        int vab; int vbc; int vca;
        int cab; int cbc; int cca;
        int g;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{100, -50, -50, 1000, -500, -500, 990, -495, -505, 256},
        '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
        '{-300, 200, 100, -2000, 1500, 500, -1980, 1510, 470, 512},
        '{1234, -4321, 3087, 7000, -3000, -4000, 6900, -3100, -3800, 128},
        '{-32768, 32767, 0, 32767, 0, 0, 0, 0, 0, 32767},
        '{0, 0, 0, -32768, 0, 0, 0, 0, 0, 32767},
        '{1, 0, 0, 0, 0, 0, 0, 0, 0, 0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] ph_a = '0, ph_b = '0, ph_c = '0;
    logic signed [DW-1:0] vl_ab = '0, vl_bc = '0, vl_ca = '0;
    logic signed [DW-1:0] vc_ab = '0, vc_bc = '0, vc_ca = '0;
    logic signed [GW-1:0] gain_word = '0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic signed [GW-1:0] wr_data = '0;
    logic signed [OW-1:0] err_ab, err_bc, err_ca;
    logic out_valid;

    always #2 clk = ~clk;

    ierr_calc #(.DW(DW), .GW(GW), .OW(OW), .FRAC(FRAC),
                .KR_RST(256), .KP_RST(256), .KD_RST(0)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c),
        .vl_ab(vl_ab), .vl_bc(vl_bc), .vl_ca(vl_ca),
        .vc_ab(vc_ab), .vc_bc(vc_bc), .vc_ca(vc_ca),
        .gain_word(gain_word),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .err_ab(err_ab), .err_bc(err_bc), .err_ca(err_ca),
        .out_valid(out_valid)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    int gkr = 256, gkp = 256, gkd = 0;   // bench copy of the gains

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(int ix, int iy, int v, int vcap, int g,
                                 int kr, int kp, int kd);
        longint il, dv, refp, s;
        il   = longint'(ix) - longint'(iy);
        dv   = longint'(v) - longint'(vcap);
        refp = (longint'(v) * longint'(g)) >>> FRAC;
        s    = refp * kr - il * kp - dv * kd;
        s    = s >>> FRAC;
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return int'(s);
    endfunction

    task automatic drive(vec_t v);
        in_valid  = 1'b1;
        ph_a  = 16'(v.ia);  ph_b  = 16'(v.ib);  ph_c  = 16'(v.ic);
        vl_ab = 16'(v.vab); vl_bc = 16'(v.vbc); vl_ca = 16'(v.vca);
        vc_ab = 16'(v.cab); vc_bc = 16'(v.cbc); vc_ca = 16'(v.cca);
        gain_word = 16'(v.g);
    endtask

    task automatic check_out(vec_t v, string req);
        chk({req, " out_valid"}, int'(out_valid), 1);
        chk({req, " err_ab"}, int'(err_ab),
            model(v.ia, v.ib, v.vab, v.cab, v.g, gkr, gkp, gkd));
        chk({req, " err_bc"}, int'(err_bc),
            model(v.ib, v.ic, v.vbc, v.cbc, v.g, gkr, gkp, gkd));
        chk({req, " err_ca"}, int'(err_ca),
            model(v.ic, v.ia, v.vca, v.cca, v.g, gkr, gkp, gkd));
    endtask

    // one sample: drive, wait three edges, check; then check the hold cycle
    task automatic run_one(vec_t v, string req);
        int h0, h1, h2;
        @(negedge clk); drive(v);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk); check_out(v, req);
        h0 = int'(err_ab); h1 = int'(err_bc); h2 = int'(err_ca);
        @(negedge clk);
        chk("R8 out_valid low after one cycle", int'(out_valid), 0);
        chk("R8 err_ab held", int'(err_ab), h0);
        chk("R8 err_bc held", int'(err_bc), h1);
        chk("R8 err_ca held", int'(err_ca), h2);
    endtask

    task automatic write_gain(int sel, int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 16'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 err_ab in reset", int'(err_ab), 0);
        chk("R1 err_bc in reset", int'(err_bc), 0);
        chk("R1 err_ca in reset", int'(err_ca), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid after reset", int'(out_valid), 0);

        // R1: reset gains 1.0 / 1.0 / 0 are in effect
        run_one(VECS[2], "R1 default gains");

        // R9: idle writes of all three gains
        write_gain(1, 128); gkp = 128;
        write_gain(2, 64);  gkd = 64;
        write_gain(0, 256); gkr = 256;

        // table walk: R2 pairing, R4 derivative, R5 floor, R6 rails
        for (int i = 0; i < NV; i++) begin
            run_one(VECS[i], $sformatf("R2 R4 R5 R6 vec%0d", i));
        end

        // R3: reference gain scales the reference term
        write_gain(0, 384); gkr = 384;
        run_one(VECS[3], "R3 ref gain 1.5");
        run_one(VECS[0], "R9 new gain used");

        // R7: back-to-back samples come out on consecutive cycles
        @(negedge clk); drive(VECS[0]);
        @(negedge clk); drive(VECS[2]);
        @(negedge clk); drive(VECS[3]);
        @(negedge clk); in_valid = 1'b0; check_out(VECS[0], "R7 burst first");
        @(negedge clk); check_out(VECS[2], "R7 burst second");
        @(negedge clk); check_out(VECS[3], "R7 burst third");
        @(negedge clk); chk("R7 out_valid drops after burst", int'(out_valid), 0);

        // R10: writes in each busy cycle are dropped
        @(negedge clk); drive(VECS[3]);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'(999);
        @(negedge clk); in_valid = 1'b0;
        wr_sel = 2'd2; wr_data = 16'(777);
        @(negedge clk); wr_sel = 2'd0; wr_data = 16'(5);
        @(negedge clk); wr_en = 1'b0;
        check_out(VECS[3], "R10 in-flight sample kept old gains");
        @(negedge clk);
        run_one(VECS[2], "R10 later sample kept old gains");

        // R10: select code 3 writes nothing
        write_gain(3, 1000);
        run_one(VECS[0], "R10 select 3 ignored");

        // R1: reset brings gains back to their reset values
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R1 err_ab cleared by reset", int'(err_ab), 0);
        rst = 1'b0;
        gkr = 256; gkp = 256; gkd = 0;
        run_one(VECS[3], "R1 gains restored");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule